// File: doc/BRIEF.md
# Flash Frame Programming Sequencer

This block turns erase and program strobes from a boundary-scan command decoder into a stream of commands for a NOR flash controller. The flash is split into equal slots, one configuration image per slot. A separate serial command path selects the active slot, and that choice fixes the base word address of every later operation. An erase request clears the selected slot one block at a time, so neighbouring slots are never touched. A program request takes one frame from the frame buffer and sends it to flash as a series of buffered-program bursts at rising addresses.

For each burst the block reads its words from the frame buffer, which has a one-cycle read latency. It passes these words to the controller's write buffer on a data strobe. It then issues a single buffered-program command that carries the burst's start address. Only one command is in flight at any time: the next one is issued only after the controller pulses `fc_done`. A frame counter inside the selected slot sets where each successive frame lands.

Top module: `flash_frame_seq`

## Requirements
- R1: While and right after reset, `busy`, `done`, `cmd_valid`, `wd_valid` and `buf_rd_en` are all low, and the slot and frame position are both zero.
- R2: An erase request issues exactly ERASE_BLOCKS commands with op code 2'b01, at addresses slot_base + k*BLOCK_WORDS for k = 0, 1, … in ascending order, where slot_base = slot*ERASE_BLOCKS*BLOCK_WORDS.
- R3: A program request issues FRAME_WORDS/BURST_WORDS commands with op code 2'b10, at addresses slot_base + frame*FRAME_WORDS + b*BURST_WORDS for b = 0, 1, … in ascending order.
- R4: Each program command is preceded, since the previous command, by exactly BURST_WORDS `wd_valid` words and is never issued in the same cycle as one. For burst b these words are frame-buffer entries b*BURST_WORDS … b*BURST_WORDS+BURST_WORDS-1 in order. They are read on `buf_rd_addr` (burst index in the upper bits, word index in the lower bits) with one cycle of read latency. Erase commands have no data words.
- R5: After a command, no further command is issued until `fc_done` has been seen.
- R6: `busy` rises in the cycle after an accepted request and stays high until the final command's `fc_done`. It then falls in the same cycle as a one-cycle `done` pulse. While `busy` is low no command or buffer read occurs.
- R7: The frame position advances by one after each completed program operation. It wraps to zero after the last frame of the slot. An erase or a slot load resets it to zero.
- R8: Erase requests, program requests and slot loads that arrive while `busy` is high are ignored.
- R9: When an erase request and a program request arrive in the same idle cycle, only the erase runs.
- R10: Every command address lies inside the slot selected by the last accepted slot load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_load | input | 1 | Strobe: take `slot_sel` as the active slot |
| slot_sel | input | SLOT_W | Slot number from the serial command path |
| erase_req | input | 1 | Strobe: erase the active slot |
| prog_req | input | 1 | Strobe: program one buffered frame |
| buf_rd_en | output | 1 | Frame-buffer read enable |
| buf_rd_addr | output | log2(FRAME_WORDS) | Frame-buffer word index |
| buf_rd_data | input | WORD_W | Frame-buffer word, one cycle after the read |
| cmd_valid | output | 1 | One-cycle command strobe to the flash controller |
| cmd_op | output | 2 | 01 block erase, 10 buffered program |
| cmd_addr | output | ADDR_W | Flash word address of the command |
| wd_valid | output | 1 | Write-buffer data strobe |
| wd_data | output | WORD_W | Write-buffer data word |
| fc_done | input | 1 | Controller finished the outstanding command |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
The bench builds the block with 4-word bursts and 16-word frames, 2 erase blocks of 64 words per slot, and 4 slots in a 10-bit address space. This gives 8 frames per slot. With these sizes the bench can visit every slot, erase each one, and program nine frames into each. The ninth frame exercises the wrap of the frame position. Every command and every data word is compared with addresses and buffer contents computed in the bench. Controller latency varies from one to three cycles, so the hold-until-done rule is tested with short and long waits.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

    typedef enum logic [1:0] {
        FOP_NONE      = 2'b00,
        FOP_BLK_ERASE = 2'b01,
        FOP_BUF_PROG  = 2'b10
    } fop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ER_ISSUE,
        S_ER_WAIT,
        S_LOAD,
        S_LOAD_END,
        S_PG_ISSUE,
        S_PG_WAIT
    } seq_state_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ffs_ctrl.sv
module ffs_ctrl
    import ffs_pkg::*;
#(
    parameter int unsigned BURST_WORDS  = 32,
    parameter int unsigned FRAME_WORDS  = 256,
    parameter int unsigned ERASE_BLOCKS = 4,
    localparam int unsigned BURSTS = FRAME_WORDS / BURST_WORDS,
    localparam int unsigned BLK_W  = idx_bits(ERASE_BLOCKS),
    localparam int unsigned BUR_W  = idx_bits(BURSTS),
    localparam int unsigned WRD_W  = idx_bits(BURST_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             erase_req,
    input  logic             prog_req,
    input  logic             fc_done,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic [BUR_W-1:0] bur_idx,
    output logic [WRD_W-1:0] wrd_idx,
    output logic [BLK_W-1:0] blk_idx,
    output logic             cmd_valid,
    output fop_e             cmd_op,
    output logic             frame_adv,
    output logic             frame_clr
);

    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(ERASE_BLOCKS - 1);
    localparam logic [BUR_W-1:0] BUR_LAST = BUR_W'(BURSTS - 1);
    localparam logic [WRD_W-1:0] WRD_LAST = WRD_W'(BURST_WORDS - 1);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            blk_idx <= '0;
            bur_idx <= '0;
            wrd_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    blk_idx <= '0;
                    bur_idx <= '0;
                    wrd_idx <= '0;
                    if (erase_req)     state <= S_ER_ISSUE;
                    else if (prog_req) state <= S_LOAD;
                end
                S_ER_ISSUE: state <= S_ER_WAIT;
                S_ER_WAIT: begin
                    if (fc_done) begin
                        if (blk_idx == BLK_LAST) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            blk_idx <= blk_idx + 1'b1;
                            state   <= S_ER_ISSUE;
                        end
                    end
                end
                S_LOAD: begin
                    if (wrd_idx == WRD_LAST) begin
                        wrd_idx <= '0;
                        state   <= S_LOAD_END;
                    end else begin
                        wrd_idx <= wrd_idx + 1'b1;
                    end
                end
                S_LOAD_END: state <= S_PG_ISSUE;
                S_PG_ISSUE: state <= S_PG_WAIT;
                S_PG_WAIT: begin
                    if (fc_done) begin
                        if (bur_idx == BUR_LAST) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            bur_idx <= bur_idx + 1'b1;
                            state   <= S_LOAD;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        rd_en     = (state == S_LOAD);
        cmd_valid = (state == S_ER_ISSUE) || (state == S_PG_ISSUE);
        cmd_op    = (state == S_ER_ISSUE) ? FOP_BLK_ERASE :
                    (state == S_PG_ISSUE) ? FOP_BUF_PROG : FOP_NONE;
        frame_adv = (state == S_PG_WAIT) && fc_done && (bur_idx == BUR_LAST);
        frame_clr = (state == S_IDLE) && erase_req;
    end

endmodule

// File: rtl/ffs_addr.sv
module ffs_addr
    import ffs_pkg::*;
#(
    parameter int unsigned ADDR_W       = 25,
    parameter int unsigned SLOT_W       = 5,
    parameter int unsigned BURST_WORDS  = 32,
    parameter int unsigned FRAME_WORDS  = 256,
    parameter int unsigned BLOCK_WORDS  = 65536,
    parameter int unsigned ERASE_BLOCKS = 4,
    localparam int unsigned SLOT_WORDS = ERASE_BLOCKS * BLOCK_WORDS,
    localparam int unsigned FRAMES     = SLOT_WORDS / FRAME_WORDS,
    localparam int unsigned FRM_W      = idx_bits(FRAMES),
    localparam int unsigned BLK_W      = idx_bits(ERASE_BLOCKS),
    localparam int unsigned BUR_W      = idx_bits(FRAME_WORDS / BURST_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_we,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              frame_adv,
    input  logic              frame_clr,
    input  fop_e              op,
    input  logic [BLK_W-1:0]  blk_idx,
    input  logic [BUR_W-1:0]  bur_idx,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic [SLOT_W-1:0] slot_q;
    logic [FRM_W-1:0]  frame_q;
    logic [ADDR_W-1:0] base;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            frame_q <= '0;
        end else begin
            if (slot_we) slot_q <= slot_sel;
            if (slot_we || frame_clr) frame_q <= '0;
            else if (frame_adv)       frame_q <= frame_q + 1'b1;
        end
    end

    always_comb begin
        base = ADDR_W'(slot_q) * ADDR_W'(SLOT_WORDS);
        if (op == FOP_BLK_ERASE)
            cmd_addr = base + ADDR_W'(blk_idx) * ADDR_W'(BLOCK_WORDS);
        else
            cmd_addr = base + ADDR_W'(frame_q) * ADDR_W'(FRAME_WORDS)
                            + ADDR_W'(bur_idx) * ADDR_W'(BURST_WORDS);
    end

endmodule

// File: rtl/flash_frame_seq.sv
module flash_frame_seq
    import ffs_pkg::*;
#(
    parameter int unsigned ADDR_W       = 25,
    parameter int unsigned WORD_W       = 16,
    parameter int unsigned SLOT_W       = 5,
    parameter int unsigned BURST_WORDS  = 32,
    parameter int unsigned FRAME_WORDS  = 256,
    parameter int unsigned BLOCK_WORDS  = 65536,
    parameter int unsigned ERASE_BLOCKS = 4,
    localparam int unsigned FIDX_W = $clog2(FRAME_WORDS),
    localparam int unsigned BLK_W  = idx_bits(ERASE_BLOCKS),
    localparam int unsigned BUR_W  = idx_bits(FRAME_WORDS / BURST_WORDS),
    localparam int unsigned WRD_W  = idx_bits(BURST_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_load,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              erase_req,
    input  logic              prog_req,
    output logic              buf_rd_en,
    output logic [FIDX_W-1:0] buf_rd_addr,
    input  logic [WORD_W-1:0] buf_rd_data,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wd_valid,
    output logic [WORD_W-1:0] wd_data,
    input  logic              fc_done,
    output logic              busy,
    output logic              done
);

    logic [BUR_W-1:0] bur_idx;
    logic [WRD_W-1:0] wrd_idx;
    logic [BLK_W-1:0] blk_idx;
    logic             frame_adv;
    logic             frame_clr;
    fop_e             op;

    ffs_ctrl #(
        .BURST_WORDS (BURST_WORDS),
        .FRAME_WORDS (FRAME_WORDS),
        .ERASE_BLOCKS(ERASE_BLOCKS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .erase_req(erase_req),
        .prog_req (prog_req),
        .fc_done  (fc_done),
        .busy     (busy),
        .done     (done),
        .rd_en    (buf_rd_en),
        .bur_idx  (bur_idx),
        .wrd_idx  (wrd_idx),
        .blk_idx  (blk_idx),
        .cmd_valid(cmd_valid),
        .cmd_op   (op),
        .frame_adv(frame_adv),
        .frame_clr(frame_clr)
    );

    ffs_addr #(
        .ADDR_W      (ADDR_W),
        .SLOT_W      (SLOT_W),
        .BURST_WORDS (BURST_WORDS),
        .FRAME_WORDS (FRAME_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .ERASE_BLOCKS(ERASE_BLOCKS)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .slot_we  (slot_load && !busy),
        .slot_sel (slot_sel),
        .frame_adv(frame_adv),
        .frame_clr(frame_clr),
        .op       (op),
        .blk_idx  (blk_idx),
        .bur_idx  (bur_idx),
        .cmd_addr (cmd_addr)
    );

    // Frame-buffer data arrives one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (rst) wd_valid <= 1'b0;
        else     wd_valid <= buf_rd_en;
    end

    assign buf_rd_addr = {bur_idx, wrd_idx};
    assign wd_data     = buf_rd_data;
    assign cmd_op      = op;

endmodule

// File: rtl/ffs_chk.sv
module ffs_chk #(
    parameter int unsigned ADDR_W      = 25,
    parameter int unsigned SLOT_W      = 5,
    parameter int unsigned BURST_WORDS = 32,
    parameter int unsigned SLOT_WORDS  = 262144
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_load,
    input logic [SLOT_W-1:0] slot_sel,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              wd_valid,
    input logic              buf_rd_en,
    input logic              fc_done
);

    localparam int unsigned WC_W = $clog2(BURST_WORDS) + 2;

    logic              outstanding;
    logic [WC_W-1:0]   wcnt;
    logic [SLOT_W-1:0] sh_slot;
    logic [ADDR_W:0]   lo;
    logic [ADDR_W:0]   hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            wcnt        <= '0;
            sh_slot     <= '0;
        end else begin
            if (cmd_valid)    outstanding <= 1'b1;
            else if (fc_done) outstanding <= 1'b0;
            if (cmd_valid)     wcnt <= '0;
            else if (wd_valid) wcnt <= wcnt + 1'b1;
            if (slot_load && !busy) sh_slot <= slot_sel;
        end
    end

    assign lo = (ADDR_W+1)'(sh_slot) * (ADDR_W+1)'(SLOT_WORDS);
    assign hi = lo + (ADDR_W+1)'(SLOT_WORDS);

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !outstanding); // R5
    AST_PROG_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |-> (wcnt == WC_W'(BURST_WORDS))); // R4
    AST_ERASE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b01) |-> (wcnt == '0)); // R2
    AST_DATA_CMD_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, wd_valid})); // R4
    AST_ADDR_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ({1'b0, cmd_addr} >= lo && {1'b0, cmd_addr} < hi)); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmd_valid && !buf_rd_en)); // R6
    AST_PROG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |-> (cmd_addr % ADDR_W'(BURST_WORDS) == '0)); // R3

endmodule

bind flash_frame_seq ffs_chk #(
    .ADDR_W     (ADDR_W),
    .SLOT_W     (SLOT_W),
    .BURST_WORDS(BURST_WORDS),
    .SLOT_WORDS (ERASE_BLOCKS * BLOCK_WORDS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .slot_load(slot_load),
    .slot_sel (slot_sel),
    .busy     (busy),
    .done     (done),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .wd_valid (wd_valid),
    .buf_rd_en(buf_rd_en),
    .fc_done  (fc_done)
);

// File: tb/flash_frame_seq_tb.sv
module flash_frame_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10, WORD_W = 16, SLOT_W = 2;
    localparam int BURST = 4, FRAME = 16, BLOCK = 64, NBLK = 2;
    localparam int SLOTW = NBLK * BLOCK;
    localparam int NFRM  = SLOTW / FRAME;
    localparam int NBUR  = FRAME / BURST;
    localparam int QMAX  = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_load = 1'b0;
    logic [SLOT_W-1:0] slot_sel = '0;
    logic erase_req = 1'b0, prog_req = 1'b0;
    logic buf_rd_en;
    logic [3:0] buf_rd_addr;
    logic [WORD_W-1:0] buf_rd_data;
    logic cmd_valid, wd_valid, busy, done;
    logic [1:0] cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [WORD_W-1:0] wd_data;
    logic fc_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_frame_seq #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W), .BURST_WORDS(BURST),
        .FRAME_WORDS(FRAME), .BLOCK_WORDS(BLOCK), .ERASE_BLOCKS(NBLK)
    ) u_dut (
        .clk(clk), .rst(rst), .slot_load(slot_load), .slot_sel(slot_sel),
        .erase_req(erase_req), .prog_req(prog_req), .buf_rd_en(buf_rd_en),
        .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wd_valid(wd_valid), .wd_data(wd_data),
        .fc_done(fc_done), .busy(busy), .done(done)
    );

    function automatic logic [WORD_W-1:0] pat(input int seed, input int a);
        return WORD_W'(seed * 733 + a * 29 + 5);
    endfunction

    // Frame buffer and flash controller models
    int cur_seed = 0;
    int lat = 1;
    int cd = 0;
    always_ff @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= pat(cur_seed, int'(buf_rd_addr));
        if (rst) begin
            cd <= 0; fc_done <= 1'b0;
        end else begin
            fc_done <= (cd == 1);
            if (cmd_valid)   cd <= lat;
            else if (cd > 0) cd <= cd - 1;
        end
    end

    // Expected command queue, filled by the stimulus
    int exp_op [QMAX];
    int exp_addr [QMAX];
    int exp_seed [QMAX];
    int exp_wb [QMAX];
    int n_exp = 0;

    // Monitor
    int mon_idx = 0, wcount = 0, mon_checks = 0, mon_errs = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && wd_valid) begin
                mon_checks++;
                if (mon_idx >= n_exp) begin
                    mon_errs++;
                    $display("FAIL R4 unexpected data word act=%0d exp=none", wd_data);
                end else if (wd_data !== pat(exp_seed[mon_idx], exp_wb[mon_idx] + wcount)) begin
                    mon_errs++;
                    $display("FAIL R4 data word act=%0h exp=%0h", wd_data,
                             pat(exp_seed[mon_idx], exp_wb[mon_idx] + wcount));
                end
                wcount++;
            end
            if (!rst && cmd_valid) begin
                mon_checks++;
                if (mon_idx >= n_exp) begin
                    mon_errs++;
                    $display("FAIL R8 extra command act=%0d/%0d exp=none", cmd_op, cmd_addr);
                end else begin
                    if (int'(cmd_op) != exp_op[mon_idx] || int'(cmd_addr) != exp_addr[mon_idx]) begin
                        mon_errs++;
                        $display("FAIL %s command act=%0d@%0d exp=%0d@%0d",
                                 (exp_op[mon_idx] == 1) ? "R2" : "R3",
                                 cmd_op, cmd_addr, exp_op[mon_idx], exp_addr[mon_idx]);
                    end
                    mon_checks++;
                    if (wcount != ((exp_op[mon_idx] == 2) ? BURST : 0)) begin
                        mon_errs++;
                        $display("FAIL R4 words before command act=%0d exp=%0d", wcount,
                                 (exp_op[mon_idx] == 2) ? BURST : 0);
                    end
                end
                wcount = 0;
                mon_idx++;
            end
        end
    end

    int checks = 0, errors = 0;
    int cur_slot = 0, cur_frame = 0, seed_ctr = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int op, input int addr, input int seed, input int wb);
        exp_op[n_exp] = op; exp_addr[n_exp] = addr;
        exp_seed[n_exp] = seed; exp_wb[n_exp] = wb;
        n_exp++;
    endtask

    // Waits for done; optional noise pulses while busy (R8)
    task automatic wait_done(input bit noise);
        bit busy_ok = 1'b1;
        bit seen = 1'b0;
        int n = 0;
        while (!seen && n < 3000) begin
            @(negedge clk);
            erase_req = 1'b0; prog_req = 1'b0; slot_load = 1'b0;
            n++;
            if (done) begin
                seen = 1'b1;
                chk(!busy, "R6 busy low with done", int'(busy), 0);
            end else begin
                if (!busy) busy_ok = 1'b0;
                if (noise && n == 5) begin
                    erase_req = 1'b1; prog_req = 1'b1; slot_load = 1'b1;
                    slot_sel = SLOT_W'(cur_slot + 1);
                end
            end
        end
        chk(seen, "R6 done pulse", int'(seen), 1);
        chk(busy_ok, "R6 busy held", int'(busy_ok), 1);
        chk(mon_idx == n_exp, "R5 all commands", mon_idx, n_exp);
        @(negedge clk);
        chk(!done, "R6 done single cycle", int'(done), 0);
    endtask

    task automatic start(input bit er, input bit pg);
        @(negedge clk);
        erase_req = er; prog_req = pg;
        @(negedge clk);
        erase_req = 1'b0; prog_req = 1'b0;
        chk(busy, "R6 busy after request", int'(busy), 1);
    endtask

    task automatic load_slot(input int s);
        @(negedge clk);
        slot_load = 1'b1; slot_sel = SLOT_W'(s);
        @(negedge clk);
        slot_load = 1'b0;
        cur_slot = s; cur_frame = 0;
    endtask

    task automatic do_erase();
        for (int k = 0; k < NBLK; k++) push(1, cur_slot * SLOTW + k * BLOCK, 0, 0);
        start(1'b1, 1'b0);
        wait_done(1'b0);
        cur_frame = 0;
    endtask

    task automatic do_prog(input bit noise);
        cur_seed = seed_ctr; seed_ctr++;
        for (int b = 0; b < NBUR; b++)
            push(2, cur_slot * SLOTW + cur_frame * FRAME + b * BURST, cur_seed, b * BURST);
        start(1'b0, 1'b1);
        wait_done(noise);
        cur_frame = (cur_frame + 1) % NFRM;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1 busy/done", int'(busy || done), 0);
        chk(!cmd_valid && !wd_valid && !buf_rd_en, "R1 strobes", int'(cmd_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !cmd_valid, "R1 after release", int'(busy), 0);
        // R1: slot and frame start at zero
        do_prog(1'b0);

        // Sweep all slots: erase (R2), nine frames (R3, R4, R7 wrap)
        for (int s = 0; s < (1 << SLOT_W); s++) begin
            lat = (s % 3) + 1;
            load_slot(s);
            do_erase();
            for (int f = 0; f <= NFRM; f++) do_prog(1'b0);
        end

        // R7: erase resets the frame position
        lat = 2;
        do_erase();
        do_prog(1'b0);

        // R8: requests and slot loads during busy are ignored
        do_prog(1'b1);
        repeat (20) @(negedge clk);
        chk(!busy && mon_idx == n_exp, "R8 no follow-on op", mon_idx, n_exp);
        do_prog(1'b0);

        // R9: erase wins over a simultaneous program request
        for (int k = 0; k < NBLK; k++) push(1, cur_slot * SLOTW + k * BLOCK, 0, 0);
        start(1'b1, 1'b1);
        wait_done(1'b0);
        repeat (10) @(negedge clk);
        chk(mon_idx == n_exp, "R9 erase only", mon_idx, n_exp);
        cur_frame = 0;
        do_prog(1'b0);

        // R10: slot switch takes effect for the next operation
        load_slot(1);
        lat = 3;
        do_prog(1'b0);
        do_erase();

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end

endmodule